// File: doc/BRIEF.md
# Eight-Pin Bidirectional I/O Port

This block gives software control over eight general-purpose pins through three small byte-wide registers on a simple synchronous register bus. A direction register decides for each pin whether it is driven or sensed. A latch register gives the level on driven pins and turns on a weak pull-up on sensed pins. A read-only sense register returns the pin levels after a two-stage synchronizer. The pad drivers outside the block take the per-pin data, output-enable and pull-up-enable signals. The raw pin levels come back into the block.

The sense register offset has a second use on writes. Every one bit written there flips the matching bit of the latch register, whatever the pin direction, so a single store can toggle a set of pins. Zero bits leave the latch alone. Reads are registered: read data is captured on the clock edge where read enable is high, and it holds its value at all other times.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous active-high reset the direction and latch registers are zero, every pin is an input (output enable low) with its pull-up off, and read data is zero.
- R2: Offset 1 holds the direction register. A bus write there stores the write data, and a read returns it. `pin_oe[i]` is 1 exactly when direction bit i is 1.
- R3: Offset 2 holds the latch register. A bus write there stores the write data, and a read returns it. `pin_out` always equals the latch register, which gives the level driven on pins whose output enable is 1.
- R4: `pin_pu[i]` is 1 exactly when direction bit i is 0 and latch bit i is 1.
- R5: A read at offset 0 returns the pin levels after two flip-flop stages. A level applied to `pin_in` before clock edge k is returned by a read issued at edge k+2 or later.
- R6: A write at offset 0 inverts each latch bit whose write-data bit is 1, for input and output pins alike. It leaves bits with write-data 0, and the whole direction register, unchanged.
- R7: Offset 3 is unmapped. A read there returns zero, and a write there changes neither register.
- R8: `bus_rdata` takes the addressed value on the clock edge after `bus_rd` is sampled high. It holds its previous value while `bus_rd` is low. When a read and a write to the same offset fall in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_out | output | 8 | Level to drive on each pin |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Per-pin pull-up enable |

## Verification
On every cycle the assertions check the following: each synchronizer stage copies the one before it, writes to each offset update or flip the latch and direction bits as required, the unmapped offset and idle cycles leave state alone, read data holds when no read is issued, and a pull-up is never enabled on a driven pin. Some behaviour needs the bench's reference model. This covers the end-to-end two-cycle latency from a pin change to a read, the exact toggle results across mixed directions, read-during-write ordering, and correct recovery from a reset in the middle of a run.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    parameter int GP_PINS   = 8;
    parameter int GP_ADDR_W = 2;

    typedef enum logic [GP_ADDR_W-1:0] {
        OFS_SENSE = 2'd0,
        OFS_DIR   = 2'd1,
        OFS_LATCH = 2'd2,
        OFS_NONE  = 2'd3
    } gp_ofs_e;

    typedef struct packed {
        gp_ofs_e ofs;
        logic    wr;
        logic    rd;
    } gp_cmd_t;

    function automatic gp_ofs_e to_ofs(input logic [GP_ADDR_W-1:0] a);
        return gp_ofs_e'(a);
    endfunction

    function automatic logic [GP_PINS-1:0] pull_mask(
        input logic [GP_PINS-1:0] dir,
        input logic [GP_PINS-1:0] lat
    );
        return ~dir & lat;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int PINS  = 8,
    parameter int DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] raw,
    output logic [PINS-1:0] synced
);

    logic [PINS-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
            stg[0] <= raw;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign synced = stg[DEPTH-1];

    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (rst)
        !rst |=> stg[0] == $past(raw)); // R5

    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_chk
            AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (rst)
                !rst |=> stg[g] == $past(stg[g-1])); // R5
        end
    endgenerate

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  gp_cmd_t         cmd,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] lat_q
);

    logic [PINS-1:0] dir_d, lat_d;

    always_comb begin
        dir_d = dir_q;
        lat_d = lat_q;
        if (cmd.wr) begin
            unique case (cmd.ofs)
                OFS_SENSE: lat_d = lat_q ^ wdata;
                OFS_DIR:   dir_d = wdata;
                OFS_LATCH: lat_d = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            lat_q <= '0;
        end else begin
            dir_q <= dir_d;
            lat_q <= lat_d;
        end
    end

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
        cmd.wr && cmd.ofs == OFS_DIR |=> dir_q == $past(wdata)); // R2
    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (rst)
        cmd.wr && cmd.ofs == OFS_LATCH |=> lat_q == $past(wdata)); // R3
    AST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        cmd.wr && cmd.ofs == OFS_SENSE |=> lat_q == ($past(lat_q) ^ $past(wdata))); // R6
    AST_TOGGLE_DIR_KEEP: assert property (@(posedge clk) disable iff (rst)
        cmd.wr && cmd.ofs == OFS_SENSE |=> $stable(dir_q)); // R6
    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
        cmd.wr && cmd.ofs == OFS_NONE |=> $stable(dir_q) && $stable(lat_q)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmd.wr |=> $stable(dir_q) && $stable(lat_q)); // R7

endmodule

// File: rtl/gpio_rdport.sv
module gpio_rdport
    import gpio_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  gp_cmd_t         cmd,
    input  logic [PINS-1:0] sense,
    input  logic [PINS-1:0] dir_q,
    input  logic [PINS-1:0] lat_q,
    output logic [PINS-1:0] rdata
);

    logic [PINS-1:0] sel;

    always_comb begin
        unique case (cmd.ofs)
            OFS_SENSE: sel = sense;
            OFS_DIR:   sel = dir_q;
            OFS_LATCH: sel = lat_q;
            default:   sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (cmd.rd) rdata <= sel;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmd.rd |=> $stable(rdata)); // R8
    AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
        cmd.rd && cmd.ofs == OFS_NONE |=> rdata == '0); // R7
    AST_RD_DIR: assert property (@(posedge clk) disable iff (rst)
        cmd.rd && cmd.ofs == OFS_DIR |=> rdata == $past(dir_q)); // R8
    AST_RD_SENSE: assert property (@(posedge clk) disable iff (rst)
        cmd.rd && cmd.ofs == OFS_SENSE |=> rdata == $past(sense)); // R5

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int PINS       = GP_PINS,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [GP_ADDR_W-1:0] bus_addr,
    input  logic                 bus_wr,
    input  logic [PINS-1:0]      bus_wdata,
    input  logic                 bus_rd,
    output logic [PINS-1:0]      bus_rdata,
    input  logic [PINS-1:0]      pin_in,
    output logic [PINS-1:0]      pin_out,
    output logic [PINS-1:0]      pin_oe,
    output logic [PINS-1:0]      pin_pu
);

    gp_cmd_t         cmd;
    logic [PINS-1:0] sense, dir_q, lat_q;

    assign cmd.ofs = to_ofs(bus_addr);
    assign cmd.wr  = bus_wr;
    assign cmd.rd  = bus_rd;

    gpio_sync #(.PINS(PINS), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (pin_in),
        .synced (sense)
    );

    gpio_regs #(.PINS(PINS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .wdata (bus_wdata),
        .dir_q (dir_q),
        .lat_q (lat_q)
    );

    gpio_rdport #(.PINS(PINS)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .sense (sense),
        .dir_q (dir_q),
        .lat_q (lat_q),
        .rdata (bus_rdata)
    );

    assign pin_out = lat_q;
    assign pin_oe  = dir_q;
    assign pin_pu  = pull_mask(dir_q, lat_q);

    AST_PU_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        (pin_pu & pin_oe) == '0); // R4
    AST_PU_FOLLOWS_LATCH: assert property (@(posedge clk) disable iff (rst)
        (pin_pu & ~pin_out) == '0); // R4

endmodule

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe, pin_pu;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] m_s1, m_s2, m_dir, m_lat, m_rd;
    logic [1:0] last_rd_addr = 2'd0;

    always #2.5 clk = ~clk;

    gpio_port uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string rd_tag(input logic [1:0] a);
        case (a)
            2'd0:    return "R8/R5 sense read";
            2'd1:    return "R8/R2 direction read";
            2'd2:    return "R8/R3 latch read";
            default: return "R8/R7 unmapped read";
        endcase
    endfunction

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input logic r, input logic [1:0] a, input logic w,
                       input logic [7:0] wd, input logic rd, input logic [7:0] pins);
        logic [7:0] sel;
        rst = r; bus_addr = a; bus_wr = w; bus_wdata = wd; bus_rd = rd; pin_in = pins;
        @(posedge clk);
        if (r) begin
            m_s1 = 0; m_s2 = 0; m_dir = 0; m_lat = 0; m_rd = 0;
        end else begin
            case (a)
                2'd0: sel = m_s2;
                2'd1: sel = m_dir;
                2'd2: sel = m_lat;
                default: sel = 8'h00;
            endcase
            if (rd) begin m_rd = sel; last_rd_addr = a; end
            m_s2 = m_s1;
            m_s1 = pins;
            if (w) begin
                case (a)
                    2'd0: m_lat = m_lat ^ wd;
                    2'd1: m_dir = wd;
                    2'd2: m_lat = wd;
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        check(pin_oe,    m_dir,          "R2 pin_oe");
        check(pin_out,   m_lat,          "R3 pin_out");
        check(pin_pu,    ~m_dir & m_lat, "R4 pin_pu");
        check(bus_rdata, m_rd,           rd_tag(last_rd_addr));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        cyc(1, 0, 0, 8'h00, 0, 8'hFF);
        cyc(1, 0, 0, 8'h00, 0, 8'hFF);
        // R1 reset state
        check(pin_oe, 8'h00, "R1 reset oe");
        check(pin_pu, 8'h00, "R1 reset pu");
        check(bus_rdata, 8'h00, "R1 reset rdata");
        cyc(0, 1, 0, 8'h00, 1, 8'hFF);
        check(bus_rdata, 8'h00, "R1 reset direction");

        // R2/R3/R4 configuration and read back
        cyc(0, 1, 1, 8'hF0, 0, 8'h00);
        cyc(0, 2, 1, 8'h5A, 0, 8'h00);
        check(pin_pu, 8'h0A, "R4 pull-up on inputs only");
        cyc(0, 1, 0, 8'h00, 1, 8'h00);
        check(bus_rdata, 8'hF0, "R2 direction readback");
        cyc(0, 2, 0, 8'h00, 1, 8'h00);
        check(bus_rdata, 8'h5A, "R3 latch readback");

        // R6 toggle through sense offset, mixed directions
        cyc(0, 0, 1, 8'h3C, 0, 8'h00);
        check(pin_out, 8'h66, "R6 toggle ones");
        check(pin_oe, 8'hF0, "R6 direction unchanged");
        cyc(0, 0, 1, 8'h00, 0, 8'h00);
        check(pin_out, 8'h66, "R6 zero write no effect");

        // R5 synchronizer latency: pins change before edge k
        cyc(0, 0, 0, 8'h00, 1, 8'hA5);
        cyc(0, 0, 0, 8'h00, 1, 8'hA5);
        check(bus_rdata, 8'h00, "R5 not yet visible");
        cyc(0, 0, 0, 8'h00, 1, 8'hA5);
        check(bus_rdata, 8'hA5, "R5 visible after two stages");
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 8'h00, 1, 8'(8'h11 * i));

        // R7 unmapped offset
        cyc(0, 3, 1, 8'hFF, 1, 8'h00);
        check(bus_rdata, 8'h00, "R7 unmapped read zero");
        check(pin_out, 8'h66, "R7 unmapped write latch");
        check(pin_oe, 8'hF0, "R7 unmapped write direction");

        // R8 hold and read-during-write
        cyc(0, 2, 0, 8'h00, 1, 8'h00);
        cyc(0, 1, 1, 8'h0F, 0, 8'h00);
        check(bus_rdata, 8'h66, "R8 hold without read");
        cyc(0, 2, 1, 8'hC3, 1, 8'h00);
        check(bus_rdata, 8'h66, "R8 read returns pre-write value");
        check(pin_out, 8'hC3, "R3 new latch");

        // mixed random traffic with one reset in the middle
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom;
            cyc(i == 200, r[1:0], r[2], r[15:8], r[3], r[23:16]);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule